// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block sits on a processor's I/O bus and watches two adjacent port addresses. A write to the lower (index) port selects one of 256 register indexes and arms the port. The next access to the upper (data) port reads or writes the selected register, and that access also disarms the port. For every I/O cycle the block raises `claim` in the same cycle if it serves the access on-chip. When `claim` is low, the surrounding bus logic runs an external I/O cycle instead.

The register space holds eight-bit control registers, one 24-bit region register exposed as three byte indexes, and two read-only identification bytes. Indexes 0xC0–0xCF and 0xFE–0xFF are always reachable. Every other index is reachable only while a four-bit unlock field in one control register holds the key value 1. The identification bytes are fixed by parameters: one byte encodes the core-to-bus clock ratio, the other holds stepping and revision.

Top module: `iocfg_port_top`

## Requirements
- R1: A write to the index port (default 0x22) latches `io_wdata` as the index and arms the port. The write is claimed when the new index is reachable (R4/R5/R6 rules).
- R2: An armed data-port (default 0x23) access is served once and disarms the port. A data-port access while disarmed is not claimed.
- R3: A read of the index port is never claimed and leaves the armed state and the index unchanged.
- R4: Indexes 0xC0–0xCF and 0xFE–0xFF are claimed on an armed data-port access whatever the unlock field holds.
- R5: Other indexes are not claimed while the unlock field differs from 1. The access still disarms the port.
- R6: With the unlock field equal to 1, every index is claimed. Indexes with no register read 0x00 and discard writes.
- R7: Writable registers sit at 0x20, 0xC1, 0xC2, 0xC3, 0xCD, 0xCE, 0xCF, 0xE8 and 0xF0. Each reads back its last written byte and resets to 0x00.
- R8: Index 0xFE reads the device ID: 0x28 for ratio 1, 0x29 for ratio 2, 0x2D for ratio 3 and 0x2C for ratio 4, plus 2 when the alternate ID is chosen. Index 0xFF reads stepping in bits 7:4 and revision in bits 3:0. Writes to both are ignored.
- R9: The unlock field is bits 7:4 of register 0xC3 and resets to 0.
- R10: Reset disarms the port, so a data-port access right after reset is not claimed.
- R11: Accesses to any other address are never claimed and do not change the armed state. `io_rdata` is 0x00 unless a claimed data-port read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | One-cycle strobe marking an I/O cycle |
| io_write | input | 1 | 1 = write cycle, 0 = read cycle |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 8 | Write data |
| claim | output | 1 | Access is served on-chip (combinational) |
| io_rdata | output | 8 | Read data for a claimed data-port read, else 0 |

## Verification
The embedded assertions check three things on every cycle: an index-port read never claims, a data-port access always leaves the port disarmed, and a claimed data-port access always targets a reachable index or happens while unlocked. They also check that unlocked armed accesses always claim and that the unlock field moves only on a served write. The bench's scenarios are needed for the rest: read-back values, the clock-ratio ID encoding, discarding of writes to reserved and ID indexes, and the effect of reset partway through a run. These are compared against a reference model over random index sequences and unlock settings.

// File: rtl/iocfg_pkg.sv
// Shared constants and helpers for the indexed configuration port.
// Assumes 8-bit indexes and a fixed set of writable register slots.
package iocfg_pkg;
    localparam int          NSLOT      = 9;
    localparam int          SLOT_W     = 4;
    localparam int          SLOT_CTRL3 = 3;
    localparam logic [3:0]  UNLOCK_KEY = 4'h1;
    localparam logic [SLOT_W-1:0] NO_SLOT = '1;

    // Map an index to its storage slot, or NO_SLOT for a reserved index.
    function automatic logic [SLOT_W-1:0] slot_of(input logic [7:0] idx);
        case (idx)
            8'h20:   return 4'd0;
            8'hC1:   return 4'd1;
            8'hC2:   return 4'd2;
            8'hC3:   return 4'd3;
            8'hCD:   return 4'd4;
            8'hCE:   return 4'd5;
            8'hCF:   return 4'd6;
            8'hE8:   return 4'd7;
            8'hF0:   return 4'd8;
            default: return NO_SLOT;
        endcase
    endfunction

    // True when an index is served on-chip under the given unlock field.
    function automatic logic idx_open(input logic [7:0] idx, input logic [3:0] key);
        return (idx[7:4] == 4'hC) || (idx[7:1] == 7'h7F) || (key == UNLOCK_KEY);
    endfunction
endpackage

// File: rtl/iocfg_seq.sv
// Index/data port sequencer: tracks the armed index and decides per cycle
// whether the access is claimed. Assumes io_valid is a one-cycle strobe.
module iocfg_seq #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic [3:0]        unlock,
    output logic              claim,
    output logic              wr_en,
    output logic              rd_en,
    output logic [7:0]        idx
);
    import iocfg_pkg::*;

    localparam logic [ADDR_W-1:0] DATA_PORT = INDEX_PORT + {{(ADDR_W-1){1'b0}}, 1'b1};

    logic       armed_q;
    logic [7:0] idx_q;
    logic       hit_index, hit_data;

    // Address decode of the two ports.
    always_comb begin
        hit_index = io_valid && (io_addr == INDEX_PORT);
        hit_data  = io_valid && (io_addr == DATA_PORT);
    end

    // Claim decision and register-bank strobes.
    always_comb begin
        claim = 1'b0;
        if (hit_index && io_write)
            claim = idx_open(io_wdata, unlock);
        else if (hit_data && armed_q)
            claim = idx_open(idx_q, unlock);
        wr_en = claim && hit_data && io_write;
        rd_en = claim && hit_data && !io_write;
    end

    // Arm on an index write, disarm on any data-port access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            idx_q   <= 8'h00;
        end else if (hit_index && io_write) begin
            armed_q <= 1'b1;
            idx_q   <= io_wdata;
        end else if (hit_data) begin
            armed_q <= 1'b0;
        end
    end

    assign idx = idx_q;

    AST_INDEX_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_write && io_addr == INDEX_PORT) |-> !claim); // R3
    AST_DATA_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_addr == DATA_PORT && !(io_write && io_addr == INDEX_PORT)) |=> !armed_q); // R2
    AST_RESET_DISARMS: assert property (@(posedge clk)
        !rst_n |=> !armed_q); // R10
    AST_LOCKED_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && io_addr == DATA_PORT) |-> (armed_q && (idx_q[7:4] == 4'hC || idx_q >= 8'hFE || unlock == 4'h1))); // R5
    AST_UNLOCKED_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_addr == DATA_PORT && armed_q && unlock == 4'h1) |-> claim); // R6
endmodule

// File: rtl/iocfg_ident.sv
// Read-only identification bytes built from parameters.
// Assumes CLK_RATIO is 1..4; any other value falls back to ratio 1.
module iocfg_ident #(
    parameter int       CLK_RATIO = 2,
    parameter bit       ID_ALT    = 1'b0,
    parameter bit [3:0] STEPPING  = 4'h1,
    parameter bit [3:0] REVISION  = 4'h3
) (
    output logic [7:0] dev_id,
    output logic [7:0] step_rev
);
    localparam logic [7:0] ALT_OFS = ID_ALT ? 8'h02 : 8'h00;

    // Ratio-dependent base code chosen at elaboration.
    generate
        if (CLK_RATIO == 2) begin : g_r2
            assign dev_id = 8'h29 + ALT_OFS;
        end else if (CLK_RATIO == 3) begin : g_r3
            assign dev_id = 8'h2D + ALT_OFS;
        end else if (CLK_RATIO == 4) begin : g_r4
            assign dev_id = 8'h2C + ALT_OFS;
        end else begin : g_r1
            assign dev_id = 8'h28 + ALT_OFS;
        end
    endgenerate

    assign step_rev = {STEPPING, REVISION};
endmodule

// File: rtl/iocfg_regs.sv
// Writable configuration byte slots plus the read mux over all indexes.
// Assumes wr_en is set only for claimed data-port writes.
module iocfg_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    input  logic [7:0] dev_id,
    input  logic [7:0] step_rev,
    output logic [7:0] rd_data,
    output logic [3:0] unlock
);
    import iocfg_pkg::*;

    logic [7:0]        slot_q [NSLOT];
    logic [SLOT_W-1:0] sel;

    assign sel = slot_of(idx);

    // One storage byte per writable slot.
    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[s] <= 8'h00;
                else if (wr_en && sel == SLOT_W'(s))
                    slot_q[s] <= wdata;
            end
        end
    endgenerate

    // Read mux: ID bytes, slots, else zero for reserved indexes.
    always_comb begin
        rd_data = 8'h00;
        if (idx == 8'hFE)
            rd_data = dev_id;
        else if (idx == 8'hFF)
            rd_data = step_rev;
        else
            for (int s = 0; s < NSLOT; s++)
                if (sel == SLOT_W'(s)) rd_data = slot_q[s];
    end

    assign unlock = slot_q[SLOT_CTRL3][7:4];

    AST_UNLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(unlock)); // R9
endmodule

// File: rtl/iocfg_port_top.sv
// Top of the indexed configuration port: sequencer, register bank, ID bytes.
// Assumes outputs are consumed combinationally in the same bus cycle.
module iocfg_port_top #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
    parameter int                CLK_RATIO  = 2,
    parameter bit                ID_ALT     = 1'b0,
    parameter bit [3:0]          STEPPING   = 4'h1,
    parameter bit [3:0]          REVISION   = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic              claim,
    output logic [7:0]        io_rdata
);
    logic       wr_en, rd_en;
    logic [7:0] idx, bank_rd, dev_id, step_rev;
    logic [3:0] unlock;

    iocfg_seq #(.ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT)) seq_i (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_wdata(io_wdata), .unlock(unlock),
        .claim(claim), .wr_en(wr_en), .rd_en(rd_en), .idx(idx));

    iocfg_ident #(.CLK_RATIO(CLK_RATIO), .ID_ALT(ID_ALT),
                  .STEPPING(STEPPING), .REVISION(REVISION)) ident_i (
        .dev_id(dev_id), .step_rev(step_rev));

    iocfg_regs regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wdata(io_wdata),
        .dev_id(dev_id), .step_rev(step_rev), .rd_data(bank_rd), .unlock(unlock));

    // Read data is driven only for a claimed data-port read.
    assign io_rdata = rd_en ? bank_rd : 8'h00;

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !claim |-> io_rdata == 8'h00); // R11
endmodule

// File: tb/iocfg_port_tb.sv
// Bench: directed corners plus seeded random traffic against a reference model.
module iocfg_port_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0, io_write = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic        claim;
    logic [7:0]  io_rdata;

    int checks = 0, fails = 0;
    bit        m_armed;
    logic [7:0] m_idx;
    logic [7:0] m_mem [256];

    always #2 clk = ~clk;

    iocfg_port_top dut_i (.clk(clk), .rst_n(rst_n), .io_valid(io_valid),
        .io_write(io_write), .io_addr(io_addr), .io_wdata(io_wdata),
        .claim(claim), .io_rdata(io_rdata));

    function automatic bit writable(input logic [7:0] i);
        return i inside {8'h20, 8'hC1, 8'hC2, 8'hC3, 8'hCD, 8'hCE, 8'hCF, 8'hE8, 8'hF0};
    endfunction
    function automatic bit reach(input logic [7:0] i);
        return (i[7:4] == 4'hC) || (i >= 8'hFE) || (m_mem[8'hC3][7:4] == 4'h1);
    endfunction
    function automatic logic [7:0] model_rd(input logic [7:0] i);
        if (i == 8'hFE) return 8'h29;   // R8 ratio 2, no alternate
        if (i == 8'hFF) return 8'h13;   // R8 stepping 1, revision 3
        return writable(i) ? m_mem[i] : 8'h00;
    endfunction

    task automatic model_reset();
        m_armed = 0; m_idx = 0;
        for (int k = 0; k < 256; k++) m_mem[k] = 8'h00;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [15:0] a, input bit wr, input logic [7:0] d, input string tag_in);
        bit e_claim;
        logic [7:0] e_rd;
        string tag;
        @(negedge clk);
        io_valid = 1; io_write = wr; io_addr = a; io_wdata = d;
        e_claim = 0; tag = "R11";
        if (a == 16'h22) begin
            tag = wr ? "R1" : "R3";
            e_claim = wr && reach(d);
        end else if (a == 16'h23) begin
            if (!m_armed) tag = "R2";
            else begin
                e_claim = reach(m_idx);
                if (m_idx >= 8'hFE) tag = "R8";
                else if (m_idx[7:4] == 4'hC) tag = "R4";
                else if (m_mem[8'hC3][7:4] != 4'h1) tag = "R5";
                else tag = writable(m_idx) ? "R7" : "R6";
            end
        end
        if (tag_in != "") tag = tag_in;
        e_rd = (e_claim && !wr && a == 16'h23) ? model_rd(m_idx) : 8'h00;
        #1;
        check(tag, claim, e_claim);
        check(tag, io_rdata, e_rd);
        @(posedge clk);
        if (a == 16'h22 && wr) begin m_armed = 1; m_idx = d; end
        else if (a == 16'h23) begin
            if (e_claim && wr && writable(m_idx)) m_mem[m_idx] = d;
            m_armed = 0;
        end
        #1 io_valid = 0;
    endtask

    task automatic acc(input logic [7:0] i, input bit wr, input logic [7:0] d, input string tag);
        op(16'h22, 1, i, "");
        op(16'h23, wr, d, tag);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        op(16'h23, 0, 0, "R10");                 // data access straight after reset
        acc(8'hC3, 0, 0, "R9");                  // unlock field resets to 0
        acc(8'h20, 1, 8'h55, "R5");              // locked: not claimed
        op(16'h23, 0, 0, "R2");                  // second data access unclaimed
        acc(8'hFE, 0, 0, "R8");
        acc(8'hFF, 0, 0, "R8");
        acc(8'hFE, 1, 8'hAA, "R8");
        acc(8'hFE, 0, 0, "R8");                  // write ignored
        acc(8'hCD, 1, 8'h12, "R4");
        acc(8'hCF, 1, 8'h34, "R4");
        acc(8'hCD, 0, 0, "R7");
        acc(8'hCF, 0, 0, "R7");
        acc(8'hC3, 1, 8'h10, "R9");              // unlock
        acc(8'h20, 1, 8'h5A, "R6");
        acc(8'h20, 0, 0, "R7");
        acc(8'hE8, 1, 8'h77, "R7");
        acc(8'hF0, 1, 8'h66, "R7");
        acc(8'hF0, 0, 0, "R7");
        acc(8'h05, 1, 8'hFF, "R6");
        acc(8'h05, 0, 0, "R6");                  // reserved reads zero
        op(16'h22, 1, 8'hC1, "R1");
        op(16'h22, 0, 0, "R3");                  // index read keeps arm
        op(16'h80, 1, 8'h00, "R11");             // foreign address keeps arm
        op(16'h23, 0, 0, "R3");
        acc(8'hC3, 1, 8'h20, "R9");              // relock with other key
        acc(8'h20, 0, 0, "R5");
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            logic [7:0]  i;
            int r = $urandom_range(0, 9);
            a = (r < 4) ? 16'h22 : (r < 9) ? 16'h23 : 16'($urandom_range(0, 255));
            case ($urandom_range(0, 5))
                0: i = 8'hC3;
                1: i = 8'hC0 + 8'($urandom_range(0, 15));
                2: i = 8'hFE + 8'($urandom_range(0, 1));
                3: i = 8'h20;
                4: i = ($urandom_range(0, 1) != 0) ? 8'hE8 : 8'hF0;
                default: i = 8'($urandom);
            endcase
            if (a == 16'h22) op(a, $urandom_range(0, 3) != 0, i, "");
            else op(a, $urandom_range(0, 1) != 0,
                    ($urandom_range(0, 2) == 0) ? 8'h10 : 8'($urandom), "");
            if (n == 2000) begin
                @(negedge clk) rst_n = 0;
                @(negedge clk) rst_n = 1;
                model_reset();
                op(16'h23, 0, 0, "R10");
                acc(8'hC3, 0, 0, "R9");
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule